// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker for Bus-Master Disk DMA

This block drives one bus-master DMA channel of a disk controller. Software places a table of 8-byte descriptors in host memory, each naming a physical region (base address and byte length). Once started, the walker reads descriptors one at a time and issues transfer requests that move data between an indexed sector buffer and host memory. Each request covers at most the bytes left in the current region and the bytes left in the buffer. Every request names the host address, the byte count, the buffer index and the direction. The memory side performs the copy and acknowledges it.

A transfer ends in one of two ways. A one-cycle `done` pulse means the whole requested byte count was moved. A one-cycle `underrun` pulse means the table ran out first. The table runs out when the descriptor carrying the end flag has been used up, or when the descriptor pointer has advanced one 4096-byte page past the table base. A start can either rewind to the table base or carry on from wherever the previous transfer stopped. The caller can also choose to throw away region bytes that are left over once the buffer is full.

Top module: `prd_walker`

## Requirements
- R1: After reset, `busy`, `done`, `underrun`, `dsc_req` and `mem_req` are all low, and the region length, end flag and descriptor pointer are cleared.
- R2: Descriptors are read from `tbl_base` with bits 1:0 forced to zero, at addresses 8 bytes apart. In `dsc_data`, bits 31:0 hold the region address, bits 47:32 the length field and bit 63 the end flag.
- R3: The region length is the length field with bit 0 cleared. A cleared result of zero stands for 65536 bytes.
- R4: Each transfer request carries `mem_len` equal to the smaller of the bytes left in the buffer and the bytes left in the region. It also carries the current region address and buffer index. `mem_we` is 1 to write to host memory and 0 to read from it, as `to_mem` selected at start.
- R5: A descriptor is read only when the current region has no bytes left. After each acknowledged chunk, the region address and buffer index grow by the chunk size, and the region and buffer counts shrink by the same amount.
- R6: If the buffer still has bytes to move when the region is empty and the end-flagged descriptor has been used, `underrun` pulses for one cycle and the walker goes idle.
- R7: No descriptor is read once the pointer is 4096 bytes or more past the table base. That case also ends in an `underrun` pulse.
- R8: When the buffer count reaches zero, including a start with `xfer_len` = 0, `done` pulses for exactly one cycle, in the same cycle that `busy` falls.
- R9: A start with `rewind` = 1 resets the pointer to the table base and empties the region. A start with `rewind` = 0 continues from the leftover region and pointer.
- R10: With `discard_tail` = 1, region bytes left over at completion are dropped. A later continuing start then reads the next descriptor. With `discard_tail` = 0 they are kept.
- R11: `start` has no effect while `busy` is high.
- R12: A request stays asserted with stable address, length and index until it is acknowledged. `dsc_req` and `mem_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer when idle |
| rewind | input | 1 | At start: restart from table base |
| discard_tail | input | 1 | At start: drop leftover region bytes at completion |
| to_mem | input | 1 | At start: 1 buffer to host, 0 host to buffer |
| tbl_base | input | AW | Descriptor table base address |
| xfer_len | input | LENW | Bytes to move for this transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse: all bytes moved |
| underrun | output | 1 | One-cycle pulse: table ended early |
| dsc_req | output | 1 | Descriptor read request |
| dsc_addr | output | AW | Descriptor address |
| dsc_ack | input | 1 | Descriptor read acknowledge |
| dsc_data | input | 64 | Descriptor contents |
| mem_req | output | 1 | Data transfer request |
| mem_we | output | 1 | Transfer direction |
| mem_addr | output | AW | Host address of chunk |
| mem_len | output | 17 | Chunk length in bytes |
| mem_idx | output | LENW | Buffer index of chunk |
| mem_ack | input | 1 | Chunk acknowledge |

## Verification
The walker is tried with tables of the following kinds:
- A single end-flagged region that exactly fits the buffer. This isolates the basic decode.
- Chains of two and three regions. These show whether the address and index carry correctly across region edges.
- Length fields with bit 0 set, and a field that masks to zero. These separate correct masking from the 64 KiB rule and from reading a zero as empty.
- Regions larger than the buffer, and tables shorter than the buffer. These tell `done` apart from `underrun`.
- An endless table with no end flag. This can only stop through the page limit, so it confirms the limit is counted from the base.
- Back-to-back transfers with and without rewind and discard. These distinguish continuing inside a region from reading a fresh descriptor.

// File: rtl/prd_walker.sv
module prd_walker #(
  parameter int AW         = 32,
  parameter int LENW       = 20,
  parameter int PAGE_BYTES = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rewind,
  input  logic            discard_tail,
  input  logic            to_mem,
  input  logic [AW-1:0]   tbl_base,
  input  logic [LENW-1:0] xfer_len,
  output logic            busy,
  output logic            done,
  output logic            underrun,
  output logic            dsc_req,
  output logic [AW-1:0]   dsc_addr,
  input  logic            dsc_ack,
  input  logic [63:0]     dsc_data,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [16:0]     mem_len,
  output logic [LENW-1:0] mem_idx,
  input  logic            mem_ack
);
  localparam int RLW = 17;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_FETCH, S_MOVE} st_t;

  st_t             st;
  logic [AW-1:0]   tbase, dptr, raddr;
  logic [RLW-1:0]  rlen;
  logic            rlast;
  logic [LENW-1:0] bleft, bidx;
  logic            we_q, disc_q, done_q, und_q;

  logic [RLW-1:0]  chunk;
  logic [15:0]     dlen;
  logic [RLW-1:0]  new_len;
  logic            page_hit;
  logic [AW-1:0]   base_al;

  assign base_al  = {tbl_base[AW-1:2], 2'b00};
  assign chunk    = (bleft < LENW'(rlen)) ? RLW'(bleft) : rlen;
  assign dlen     = dsc_data[47:32] & 16'hFFFE;
  assign new_len  = (dlen == 16'd0) ? RLW'(17'h10000) : {1'b0, dlen};
  assign page_hit = (dptr - tbase) >= AW'(PAGE_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tbase  <= '0;
      dptr   <= '0;
      raddr  <= '0;
      rlen   <= '0;
      rlast  <= 1'b0;
      bleft  <= '0;
      bidx   <= '0;
      we_q   <= 1'b0;
      disc_q <= 1'b0;
      done_q <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      und_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          bleft  <= xfer_len;
          bidx   <= '0;
          we_q   <= to_mem;
          disc_q <= discard_tail;
          if (rewind) begin
            tbase <= base_al;
            dptr  <= base_al;
            raddr <= '0;
            rlen  <= '0;
            rlast <= 1'b0;
          end
          st <= S_CHECK;
        end
        S_CHECK: begin
          if (bleft == '0) begin
            if (disc_q) rlen <= '0;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (rlen != '0) begin
            st <= S_MOVE;
          end else if (rlast || page_hit) begin
            und_q <= 1'b1;
            st    <= S_IDLE;
          end else begin
            st <= S_FETCH;
          end
        end
        S_FETCH: if (dsc_ack) begin
          raddr <= AW'(dsc_data[31:0]);
          rlen  <= new_len;
          rlast <= dsc_data[63];
          dptr  <= dptr + AW'(8);
          st    <= S_CHECK;
        end
        S_MOVE: if (mem_ack) begin
          raddr <= raddr + AW'(chunk);
          rlen  <= rlen - chunk;
          bleft <= bleft - LENW'(chunk);
          bidx  <= bidx + LENW'(chunk);
          st    <= S_CHECK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign underrun = und_q;
  assign dsc_req  = (st == S_FETCH);
  assign dsc_addr = dptr;
  assign mem_req  = (st == S_MOVE);
  assign mem_we   = we_q;
  assign mem_addr = raddr;
  assign mem_len  = chunk;
  assign mem_idx  = bidx;
endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk #(
  parameter int AW   = 32,
  parameter int LENW = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            underrun,
  input logic            dsc_req,
  input logic [AW-1:0]   dsc_addr,
  input logic            dsc_ack,
  input logic            mem_req,
  input logic [AW-1:0]   mem_addr,
  input logic [16:0]     mem_len,
  input logic [LENW-1:0] mem_idx,
  input logic            mem_ack
);
  // R12
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && dsc_req));

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_idx));

  // R12
  dsc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_req && !dsc_ack |=> dsc_req && $stable(dsc_addr));

  // R4
  chunk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != 17'd0) && (mem_len <= 17'h10000));

  // R2
  dsc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_req |-> dsc_addr[1:0] == 2'b00);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !underrun);

  // R6
  und_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);
endmodule

bind prd_walker prd_walker_chk #(.AW(AW), .LENW(LENW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .underrun(underrun),
  .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_ack(dsc_ack),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
  .mem_idx(mem_idx), .mem_ack(mem_ack)
);

// File: tb/prd_walker_tb.sv
module prd_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, rewind = 1'b0, discard_tail = 1'b0, to_mem = 1'b0;
  logic [31:0] tbl_base = 32'h100;
  logic [19:0] xfer_len = '0;
  logic        busy, done, underrun, dsc_req, mem_req, mem_we;
  logic [31:0] dsc_addr, mem_addr;
  logic        dsc_ack = 1'b0, mem_ack = 1'b0;
  logic [63:0] dsc_data = '0;
  logic [16:0] mem_len;
  logic [19:0] mem_idx;

  always #10 clk = ~clk;

  prd_walker u_dut (.*);

  typedef struct packed {
    logic [31:0] d0; logic [31:0] d1; logic [19:0] xfer; logic dir; logic under;
    logic [9:0] chunks; logic [9:0] fetches; logic [31:0] laddr; logic [16:0] llen;
    logic [19:0] lidx; logic [19:0] total;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{32'h8000_0200, 32'h0,         20'd512,    1'b1, 1'b0, 10'd1, 10'd1, 32'h10000, 17'h200,   20'h0,   20'd512},
    '{32'h0000_0100, 32'h8000_0100, 20'd512,    1'b1, 1'b0, 10'd2, 10'd2, 32'h20000, 17'h100,   20'h100, 20'd512},
    '{32'h0000_0101, 32'h8000_0101, 20'd512,    1'b1, 1'b0, 10'd2, 10'd2, 32'h20000, 17'h100,   20'h100, 20'd512},
    '{32'h8000_0000, 32'h0,         20'h10000,  1'b1, 1'b0, 10'd1, 10'd1, 32'h10000, 17'h10000, 20'h0,   20'h10000},
    '{32'h8000_0100, 32'h0,         20'd512,    1'b1, 1'b1, 10'd1, 10'd1, 32'h10000, 17'h100,   20'h0,   20'd256},
    '{32'h8000_0400, 32'h0,         20'd256,    1'b1, 1'b0, 10'd1, 10'd1, 32'h10000, 17'h100,   20'h0,   20'd256},
    '{32'h0000_0100, 32'h0000_0080, 20'h190,    1'b1, 1'b0, 10'd3, 10'd3, 32'h30000, 17'h10,    20'h180, 20'h190},
    '{32'h0000_0100, 32'h8000_0100, 20'd512,    1'b0, 1'b0, 10'd2, 10'd2, 32'h20000, 17'h100,   20'h100, 20'd512},
    '{32'h0000_0001, 32'h8000_0010, 20'h100,    1'b1, 1'b0, 10'd1, 10'd1, 32'h10000, 17'h100,   20'h0,   20'h100}
  };

  int cmp = 0, bad = 0, cyc = 0;
  logic [31:0] cur_d0, cur_d1;
  bit   pagemode = 1'b0, cur_dir;
  int   n_chunk, n_fetch, total, we_bad, overlap, mcnt;
  logic [31:0] f_addr, l_addr, f_fetch, l_fetch;
  logic [16:0] f_len, l_len;
  logic [19:0] f_idx, l_idx;
  bit   got_done, got_und, post_pulse;

  function automatic logic [63:0] desc_at(input logic [31:0] a);
    logic [31:0] k;
    k = (a - {tbl_base[31:2], 2'b00}) >> 3;
    if (pagemode) return {32'h0000_0008, k << 8};
    if (k == 0) return {cur_d0, 32'h0001_0000};
    if (k == 1) return {cur_d1, 32'h0002_0000};
    return {32'h8000_0010, (k + 32'd1) << 16};
  endfunction

  always @(negedge clk) begin
    if (mem_req && dsc_req) overlap++;
    if (dsc_ack) dsc_ack = 1'b0;
    else if (dsc_req) begin
      dsc_ack  = 1'b1;
      dsc_data = desc_at(dsc_addr);
      if (n_fetch == 0) f_fetch = dsc_addr;
      l_fetch = dsc_addr;
      n_fetch++;
    end
    if (mem_ack) begin
      mem_ack = 1'b0; mcnt = 0;
    end else if (mem_req) begin
      mcnt++;
      if (mcnt >= 2) begin
        mem_ack = 1'b1;
        if (n_chunk == 0) begin f_addr = mem_addr; f_len = mem_len; f_idx = mem_idx; end
        l_addr = mem_addr; l_len = mem_len; l_idx = mem_idx;
        total += int'(mem_len);
        if (mem_we != cur_dir) we_bad++;
        n_chunk++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      bad++;
      $display("FAIL watchdog: act=%0d cycles exp=<180000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    cmp++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit rew, input bit disc, input bit dir, input logic [19:0] xl, input bit poke);
    int w;
    n_chunk = 0; n_fetch = 0; total = 0; we_bad = 0; mcnt = 0;
    f_addr = '0; l_addr = '0; f_len = '0; l_len = '0; f_idx = '0; l_idx = '0;
    f_fetch = '0; l_fetch = '0;
    cur_dir = dir;
    @(negedge clk);
    start = 1'b1; rewind = rew; discard_tail = disc; to_mem = dir; xfer_len = xl;
    @(negedge clk);
    start = 1'b0; xfer_len = 20'h7; to_mem = ~dir;
    w = 0;
    while (!done && !underrun && w < 100000) begin
      start = (poke && w == 3);
      if (poke && w == 3) xfer_len = 20'd16;
      @(negedge clk);
      w++;
    end
    start = 1'b0;
    got_done = done; got_und = underrun;
    @(negedge clk);
    post_pulse = done | underrun;
  endtask

  initial begin
    #5;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 reqs", {dsc_req, mem_req}, 0);
    chk("R1 pulses", {done, underrun}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      cur_d0 = VECS[i].d0; cur_d1 = VECS[i].d1;
      run(1'b1, 1'b1, VECS[i].dir, VECS[i].xfer, 1'b0);
      // R6 / R8 outcome
      chk($sformatf("R6 R8 outcome v%0d", i), {got_done, got_und}, {~VECS[i].under, VECS[i].under});
      chk($sformatf("R4 chunks v%0d", i), n_chunk, VECS[i].chunks);
      chk($sformatf("R5 fetches v%0d", i), n_fetch, VECS[i].fetches);
      chk($sformatf("R3 R5 last addr v%0d", i), l_addr, VECS[i].laddr);
      chk($sformatf("R3 R4 last len v%0d", i), l_len, VECS[i].llen);
      chk($sformatf("R5 last idx v%0d", i), l_idx, VECS[i].lidx);
      chk($sformatf("R4 total v%0d", i), total, VECS[i].total);
      chk($sformatf("R4 direction v%0d", i), we_bad, 0);
      chk($sformatf("R8 one-cycle pulse v%0d", i), post_pulse, 0);
    end

    // R2 unaligned base, 8-byte stride
    tbl_base = 32'h203; cur_d0 = 32'h0000_0100; cur_d1 = 32'h0000_0080;
    run(1'b1, 1'b1, 1'b1, 20'h190, 1'b0);
    chk("R2 first fetch", f_fetch, 32'h200);
    chk("R2 last fetch", l_fetch, 32'h210);

    // R7 page limit on an endless table
    tbl_base = 32'h100; pagemode = 1'b1;
    run(1'b1, 1'b1, 1'b1, 20'd8000, 1'b0);
    chk("R7 underrun", {got_done, got_und}, 2'b01);
    chk("R7 fetches", n_fetch, 512);
    chk("R7 total", total, 4096);
    chk("R7 last fetch", l_fetch, 32'h10F8);
    pagemode = 1'b0;

    // R9 continue without rewind, R10 keep tail
    cur_d0 = 32'h0000_0100; cur_d1 = 32'h8000_0100;
    run(1'b1, 1'b0, 1'b1, 20'd100, 1'b0);
    chk("R10 first part", {f_addr, 15'd0, f_len}, {32'h10000, 15'd0, 17'd100});
    run(1'b0, 1'b0, 1'b1, 20'd200, 1'b0);
    chk("R9 continue fetches", n_fetch, 1);
    chk("R9 continue first", {f_addr, 15'd0, f_len}, {32'h10064, 15'd0, 17'd156});
    chk("R9 continue last", {l_addr, l_idx, l_len}, {32'h20000, 20'd156, 17'd44});
    chk("R9 continue ptr", l_fetch, 32'h108);
    // R9 rewind, R10 discard tail
    run(1'b1, 1'b1, 1'b1, 20'd100, 1'b0);
    chk("R9 rewind fetch", f_fetch, 32'h100);
    chk("R9 rewind addr", f_addr, 32'h10000);
    run(1'b0, 1'b0, 1'b1, 20'd50, 1'b0);
    chk("R10 discard next region", {f_addr, 15'd0, f_len}, {32'h20000, 15'd0, 17'd50});
    chk("R10 discard fetch", n_fetch, 1);

    // R11 start while busy
    run(1'b1, 1'b1, 1'b1, 20'd512, 1'b1);
    chk("R11 total unchanged", total, 512);
    chk("R11 done", got_done, 1);
    chk("R11 idle after", {busy, post_pulse}, 0);

    // R8 zero-length transfer
    run(1'b1, 1'b1, 1'b1, 20'd0, 1'b0);
    chk("R8 zero done", {got_done, got_und}, 2'b10);
    chk("R8 zero no traffic", n_chunk + n_fetch, 0);

    // R12 request exclusion
    chk("R12 overlap", overlap, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
    $finish;
  end
endmodule